// File: doc/BRIEF.md
# Hamming-Preserving Bitwise Logic Unit

This block applies a bitwise logic operation to two operands. Each operand is a seven-bit single-error-correcting codeword that carries four data bits. The result is itself a codeword for the operation applied to the two data nibbles. The logic is arranged so that a fault on any one internal path disturbs at most one bit of the result, and a single corrector at the output can repair that bit.

The linear operations (XOR and NOT) work one codeword position at a time, and each position has its own gate. The nonlinear operations (AND, OR, NAND, NOR) work differently. One four-bit block produces the data half of the result. Each check bit then comes from a private recomputation of the operation, limited to the three data bits that check bit covers, followed by its own parity tree. No check bit is ever derived from the result's data bits. A one-hot fault-injection input lets a testbench invert any single path: one of the four data paths or one of the three check recomputations.

Operands enter through a valid/ready handshake and results leave through one. The output side has a single register stage. `in_ready` is high whenever that stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the stage holds its contents unchanged. An accepted operand pair shows up at the output on the next clock edge. The corrector works on the registered word and reports the syndrome, a corrected flag, the repaired codeword and its data nibble.

Top module: `hd_logic_unit`

## Requirements
- R1: Codeword bit i holds position i+1. Data bits d1..d4 (data[0]..data[3]) sit at bits 2, 4, 5 and 6. Check bits sit at bits 0, 1 and 3. The check at bit 0 is the XOR of d1, d2 and d4. The check at bit 1 is the XOR of d1, d3 and d4. The check at bit 3 is the XOR of d2, d3 and d4.
- R2: With op_sel 0 (XOR) and no fault, out_code equals the codeword of a_data XOR b_data.
- R3: With op_sel 1 (NOT), b_code has no effect and, with no fault, out_code equals the codeword of the inverted a_data.
- R4: With op_sel 2 (AND), 3 (OR), 4 (NAND) or 5 (NOR) and no fault, out_code equals the codeword of that bitwise operation on the two data nibbles.
- R5: fault_mask is one-hot or zero whenever in_valid is high. Setting bit i inverts only the path that produces codeword bit i of the accepted transaction. Every other bit of out_code is left as it would be without the fault.
- R6: The syndrome equals the position number (1..7) of a single flipped bit, or 0 for a valid codeword. out_corrected is high exactly when the syndrome is nonzero. out_fixed is the fault-free result codeword and out_data is its data nibble.
- R7: in_ready equals (not out_valid) or out_ready. An accepted pair sets out_valid on the next clock edge. While out_valid is high and out_ready is low, out_valid stays high and out_code does not change.
- R8: While rst_n is low, out_valid is low and in_ready is high.
- R9: op_sel values 6 and 7 produce the all-zero codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Unit can take an operand pair |
| op_sel | input | 3 | Operation code |
| a_code | input | 7 | First operand codeword |
| b_code | input | 7 | Second operand codeword |
| fault_mask | input | 7 | One-hot fault injection, one bit per codeword path |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_code | output | 7 | Protected result codeword as computed |
| out_fixed | output | 7 | Result codeword after single-error correction |
| out_data | output | 4 | Data nibble of the corrected result |
| out_syndrome | output | 3 | Syndrome of out_code |
| out_corrected | output | 1 | A bit of out_code was repaired |

## Verification
Several properties are checked on every cycle. With no fault injected, the selected lane must produce a valid codeword. The corrected word must always have a zero syndrome and must differ from the raw word in at most one bit. The fault mask must stay one-hot, and the output stage must hold steady under back-pressure. Only the bench scenarios can show that the values are correct. These scenarios cover every operation code over all operand pairs, and for each of them every single fault position. Together they show that each injected fault lands on exactly its own position and that the corrector returns the fault-free codeword of the reference operation.

// File: rtl/hdl_pkg.sv
`timescale 1ns/1ps
package hdl_pkg;
  localparam int DW = 4;
  localparam int PW = 3;
  localparam int CW = DW + PW;

  localparam logic [2:0] OP_XOR  = 3'd0;
  localparam logic [2:0] OP_NOT  = 3'd1;
  localparam logic [2:0] OP_AND  = 3'd2;
  localparam logic [2:0] OP_OR   = 3'd3;
  localparam logic [2:0] OP_NAND = 3'd4;
  localparam logic [2:0] OP_NOR  = 3'd5;

  // codeword bit that carries data bit k
  function automatic int data_pos(int k);
    case (k)
      0:       return 2;
      1:       return 4;
      2:       return 5;
      default: return 6;
    endcase
  endfunction

  // codeword bit that carries check bit j (positions 1, 2, 4)
  function automatic int par_pos(int j);
    return (1 << j) - 1;
  endfunction

  // check bit j covers data bit k when position of k has bit j set
  function automatic bit covers(int j, int k);
    return (((data_pos(k) + 1) >> j) & 1) != 0;
  endfunction

  function automatic logic [CW-1:0] cw_encode(logic [DW-1:0] d);
    logic [CW-1:0] c;
    logic p;
    c = '0;
    for (int k = 0; k < DW; k++) c[data_pos(k)] = d[k];
    for (int j = 0; j < PW; j++) begin
      p = 1'b0;
      for (int k = 0; k < DW; k++) if (covers(j, k)) p = p ^ d[k];
      c[par_pos(j)] = p;
    end
    return c;
  endfunction

  function automatic logic [DW-1:0] cw_data(logic [CW-1:0] c);
    logic [DW-1:0] d;
    for (int k = 0; k < DW; k++) d[k] = c[data_pos(k)];
    return d;
  endfunction

  function automatic logic [PW-1:0] cw_syndrome(logic [CW-1:0] c);
    logic [PW-1:0] s;
    for (int j = 0; j < PW; j++) begin
      s[j] = 1'b0;
      for (int i = 0; i < CW; i++) if ((((i + 1) >> j) & 1) != 0) s[j] = s[j] ^ c[i];
    end
    return s;
  endfunction

  // one bit of a nonlinear operation; unused codes give 0
  function automatic logic bit_op(logic [2:0] op, logic x, logic y);
    case (op)
      OP_AND:  return x & y;
      OP_OR:   return x | y;
      OP_NAND: return ~(x & y);
      OP_NOR:  return ~(x | y);
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/hdl_lin_lane.sv
`timescale 1ns/1ps
// Linear lane: one gate per codeword position, check bits included.
module hdl_lin_lane
  import hdl_pkg::*;
#(
  parameter bit NOT_VIA_XOR = 1'b0
) (
  input  logic          is_not,
  input  logic [CW-1:0] a_c,
  input  logic [CW-1:0] b_c,
  input  logic [CW-1:0] flip,
  output logic [CW-1:0] res
);
  localparam logic [CW-1:0] ONES_CW = cw_encode({DW{1'b1}});

  for (genvar i = 0; i < CW; i++) begin : g_pos
    if (NOT_VIA_XOR) begin : g_xor_not
      // NOT as XOR against the all-ones codeword
      assign res[i] = (a_c[i] ^ (is_not ? ONES_CW[i] : b_c[i])) ^ flip[i];
    end else begin : g_inv_not
      assign res[i] = (is_not ? ~a_c[i] : (a_c[i] ^ b_c[i])) ^ flip[i];
    end
  end
endmodule

// File: rtl/hdl_nl_lane.sv
`timescale 1ns/1ps
// Nonlinear lane: data block plus one private recomputation per check bit.
module hdl_nl_lane
  import hdl_pkg::*;
(
  input  logic [2:0]    op,
  input  logic [DW-1:0] a_d,
  input  logic [DW-1:0] b_d,
  input  logic [CW-1:0] flip,
  output logic [CW-1:0] res
);
  logic [DW-1:0] dbit;
  logic [PW-1:0] pbit;

  for (genvar k = 0; k < DW; k++) begin : g_data
    assign dbit[k] = bit_op(op, a_d[k], b_d[k]) ^ flip[data_pos(k)];
  end

  for (genvar j = 0; j < PW; j++) begin : g_chk
    logic [DW-1:0] part;
    for (genvar k = 0; k < DW; k++) begin : g_cov
      if (covers(j, k)) begin : g_on
        assign part[k] = bit_op(op, a_d[k], b_d[k]);
      end else begin : g_off
        assign part[k] = 1'b0;
      end
    end
    assign pbit[j] = (^part) ^ flip[par_pos(j)];
  end

  always_comb begin
    res = '0;
    for (int k = 0; k < DW; k++) res[data_pos(k)] = dbit[k];
    for (int j = 0; j < PW; j++) res[par_pos(j)] = pbit[j];
  end
endmodule

// File: rtl/hdl_corrector.sv
`timescale 1ns/1ps
module hdl_corrector
  import hdl_pkg::*;
(
  input  logic [CW-1:0] raw,
  output logic [PW-1:0] syn,
  output logic [CW-1:0] fixed,
  output logic [DW-1:0] data,
  output logic          corrected
);
  always_comb begin
    syn       = cw_syndrome(raw);
    fixed     = raw;
    corrected = 1'b0;
    if (syn != '0) begin
      fixed[int'(syn) - 1] = ~raw[int'(syn) - 1];
      corrected = 1'b1;
    end
    data = cw_data(fixed);
  end

  always_comb begin
    // R6
    fixed_valid_chk: assert (cw_syndrome(fixed) == '0);
    // R6
    one_flip_chk: assert ($countones(raw ^ fixed) <= 1);
  end
endmodule

// File: rtl/hd_logic_unit.sv
`timescale 1ns/1ps
module hd_logic_unit
  import hdl_pkg::*;
#(
  parameter bit NOT_VIA_XOR = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    op_sel,
  input  logic [CW-1:0] a_code,
  input  logic [CW-1:0] b_code,
  input  logic [CW-1:0] fault_mask,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_code,
  output logic [CW-1:0] out_fixed,
  output logic [DW-1:0] out_data,
  output logic [PW-1:0] out_syndrome,
  output logic          out_corrected
);
  logic [CW-1:0] lin_res, nl_res, pick, raw_q;
  logic          is_lin;

  hdl_lin_lane #(.NOT_VIA_XOR(NOT_VIA_XOR)) u_lin (
    .is_not (op_sel == OP_NOT),
    .a_c    (a_code),
    .b_c    (b_code),
    .flip   (fault_mask),
    .res    (lin_res)
  );

  hdl_nl_lane u_nl (
    .op   (op_sel),
    .a_d  (cw_data(a_code)),
    .b_d  (cw_data(b_code)),
    .flip (fault_mask),
    .res  (nl_res)
  );

  assign is_lin = (op_sel == OP_XOR) || (op_sel == OP_NOT);
  assign pick   = is_lin ? lin_res : nl_res;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      raw_q     <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      raw_q     <= pick;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_code = raw_q;

  hdl_corrector u_fix (
    .raw       (raw_q),
    .syn       (out_syndrome),
    .fixed     (out_fixed),
    .data      (out_data),
    .corrected (out_corrected)
  );

  always_comb begin
    if (rst_n && in_valid && fault_mask == '0) begin
      // R2 R4 R9
      lane_codeword_chk: assert (cw_syndrome(pick) == '0);
    end
  end

  // R5
  fault_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0(fault_mask));

  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));
endmodule

// File: tb/sim_hd_logic_unit.sv
`timescale 1ns/1ps
module sim_hd_logic_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] op_sel = 3'd0;
  logic [6:0] a_code = '0, b_code = '0, fault_mask = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [6:0] out_code, out_fixed;
  logic [3:0] out_data;
  logic [2:0] out_syndrome;
  logic       out_corrected;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit all_sent = 1'b0;

  typedef struct packed {
    logic [6:0] raw;
    logic [6:0] fixed;
    logic [3:0] data;
    logic [2:0] syn;
    logic       cor;
    logic [2:0] op;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  hd_logic_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sel(op_sel), .a_code(a_code), .b_code(b_code), .fault_mask(fault_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .out_fixed(out_fixed), .out_data(out_data), .out_syndrome(out_syndrome),
    .out_corrected(out_corrected)
  );

  // R1 layout, written out independently
  function automatic logic [6:0] enc(logic [3:0] d);
    enc[0] = d[0] ^ d[1] ^ d[3];
    enc[1] = d[0] ^ d[2] ^ d[3];
    enc[2] = d[0];
    enc[3] = d[1] ^ d[2] ^ d[3];
    enc[4] = d[1];
    enc[5] = d[2];
    enc[6] = d[3];
  endfunction

  function automatic logic [3:0] ref_op(logic [2:0] op, logic [3:0] a, logic [3:0] b);
    case (op)
      3'd0: return a ^ b;
      3'd1: return ~a;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return ~(a & b);
      3'd5: return ~(a | b);
      default: return 4'd0;
    endcase
  endfunction

  function automatic string tag(logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd6, 3'd7: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // driver: pushes expected item when the pair is accepted
  task automatic send(logic [2:0] op, logic [3:0] a, logic [3:0] b, int fpos);
    item_t it;
    logic [6:0] m;
    logic [3:0] d;
    m = (fpos == 0) ? 7'd0 : 7'(1 << (fpos - 1));
    d = ref_op(op, a, b);
    it.raw = enc(d) ^ m;
    it.fixed = enc(d);
    it.data = d;
    it.syn = 3'(fpos);
    it.cor = (fpos != 0);
    it.op = op;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; a_code = enc(a); b_code = enc(b); fault_mask = m;
    forever begin
      #1;
      if (in_ready) begin exp_q.push_back(it); break; end
      @(negedge clk);
    end
  endtask

  // monitor: drives back-pressure, pops and compares
  initial begin : monitor
    bit prev_stall = 1'b0;
    logic [6:0] prev_code = '0;
    item_t e;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) out_ready = !((cyc % 5) == 3 || (cyc % 17) == 0);
      #1;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
      if (rst_n) begin
        // R7 ready rule
        chk(in_ready == (!out_valid || out_ready), "R7", "in_ready", int'(in_ready), int'(!out_valid || out_ready));
        if (prev_stall) begin
          // R7 hold under back-pressure
          chk(out_valid && out_code == prev_code, "R7", "stall hold", int'(out_code), int'(prev_code));
        end
        prev_stall = out_valid && !out_ready;
        prev_code = out_code;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected result", int'(out_code), 0);
          end else begin
            e = exp_q.pop_front();
            // R5 raw word carries exactly the injected flip
            chk(out_code == e.raw, e.cor ? "R5" : tag(e.op), "out_code", int'(out_code), int'(e.raw));
            // R6 corrector outputs
            chk(out_syndrome == e.syn, "R6", "syndrome", int'(out_syndrome), int'(e.syn));
            chk(out_corrected == e.cor, "R6", "corrected", int'(out_corrected), int'(e.cor));
            chk(out_fixed == e.fixed, "R6", "fixed", int'(out_fixed), int'(e.fixed));
            chk(out_data == e.data, tag(e.op), "data", int'(out_data), int'(e.data));
          end
        end
      end
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #1;
    // R8 reset state
    chk(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8", "in_ready in reset", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 latency: result valid one edge after acceptance
    send(3'd4, 4'hA, 4'h6, 0);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid == 1'b1, "R7", "valid after accept", int'(out_valid), 1);

    // R3 b_code ignored for NOT: same a, different b
    send(3'd1, 4'h5, 4'h0, 0);
    send(3'd1, 4'h5, 4'hF, 0);

    // full sweep: every op, operand pair and single-fault position (R2 R3 R4 R5 R6 R9)
    for (int op = 0; op < 8; op++)
      for (int fp = 0; fp < 8; fp++)
        for (int ab = 0; ab < 256; ab++)
          send(3'(op), 4'(ab >> 4), 4'(ab), fp);
    @(negedge clk);
    in_valid = 1'b0;
    fault_mask = '0;
    all_sent = 1'b1;
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R7", "drained", int'(out_valid), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule